// File: doc/BRIEF.md
# Section Filter Bank with Demodulator Mapping

This block decides whether an encapsulated section that arrives from a satellite demodulator should be forwarded as an Ethernet frame or dropped. It holds eight filters. Each filter has an enable bit, a 13-bit packet identifier (PID) and a 48-bit destination MAC address. A section is compared in two stages. The PID stage runs first. The MAC stage then looks only at filters whose PID stage passed. The lowest-numbered filter that passes both stages wins, and its index is reported together with a forward indication. A section that no filter accepts produces a drop indication.

The eight filters are shared between one or two demodulators. In single mode every filter is eligible for every section. In dual mode the lower four filters serve the first demodulator and the upper four serve the second. The source of each section is given by its demodulator tag.

Section metadata enters on a valid/ready stream. Each accepted section produces exactly one result on a valid/ready result stream, one clock after acceptance. The input is ready whenever the result register is empty or is being taken in the same cycle. A result that is not taken stays unchanged, so back-pressure on the result side stalls the input side. The configuration inputs and the mode select are plain levels. They are sampled in the cycle a section is accepted.

Top module: `sfb_filter_bank`

## Requirements
- R1: A filter whose enable bit in `flt_en` is 0 never matches, even when its PID and MAC both equal those of the section.
- R2: A filter passes the PID stage only when `sec_pid` equals its 13-bit PID field (filter i occupies bits [13*i+12:13*i] of `flt_pid`). A filter whose MAC equals the section's MAC but whose PID differs does not forward.
- R3: An accepted section whose PID and MAC both equal those of an enabled, eligible filter produces a result with `res_fwd`=1, `res_drop`=0 and `res_idx` equal to that filter's number (MAC of filter i at bits [48*i+47:48*i] of `flt_mac`).
- R4: When several filters match, `res_idx` is the lowest-numbered matching filter.
- R5: An accepted section that no filter matches produces a result with `res_drop`=1, `res_fwd`=0 and `res_idx`=0. `res_fwd` and `res_drop` are both 0 whenever `res_valid` is 0.
- R6: With `dual_mode`=0 all eight filters are eligible, and `sec_demod` has no effect on the result.
- R7: With `dual_mode`=1, a section with `sec_demod`=0 can match only filters 0 to 3, and a section with `sec_demod`=1 can match only filters 4 to 7.
- R8: A section accepted at a clock edge (`sec_valid` and `sec_ready` both 1) has its result on the outputs with `res_valid`=1 right after that edge.
- R9: `sec_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. While `res_valid`=1 and `res_ready`=0, the result outputs hold their values.
- R10: While `rst_n` is 0 and after it is released, `res_valid` is 0 and `sec_ready` is 1 until a section is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dual_mode | input | 1 | 0: one demodulator uses all filters; 1: filters split in halves |
| flt_en | input | 8 | Per-filter enable |
| flt_pid | input | 104 | Packed per-filter PID, 13 bits each |
| flt_mac | input | 384 | Packed per-filter MAC, 48 bits each |
| sec_valid | input | 1 | Section metadata valid |
| sec_ready | output | 1 | Block can accept a section |
| sec_demod | input | 1 | Demodulator that delivered the section |
| sec_pid | input | 13 | Section packet identifier |
| sec_mac | input | 48 | Section destination MAC |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Downstream takes the result |
| res_fwd | output | 1 | Forward strobe (qualified by res_valid) |
| res_drop | output | 1 | Drop strobe (qualified by res_valid) |
| res_idx | output | 3 | Index of the matching filter, 0 on drop |

## Verification
On every cycle the assertions check the result handshake. A stalled result must hold. An accepted section must yield a result in the next cycle. Forward and drop must be mutually exclusive and appear only with a valid result. In dual mode the reported filter must lie in the half that belongs to the section's demodulator, and a forwarded index must have been enabled at acceptance. Some behaviours can be shown only by the bench's scenarios, which compare against a behavioural model. These are: the PID-before-MAC gating, lowest-index priority among duplicate filters, the fact that the demodulator tag is ignored in single mode, and the exact drop decisions for near-miss sections.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int unsigned SFB_NUM_FLT = 8;
  localparam int unsigned SFB_PID_W   = 13;
  localparam int unsigned SFB_MAC_W   = 48;
  localparam int unsigned SFB_IDX_W   = $clog2(SFB_NUM_FLT);

  // Decision carried in the result register.
  typedef enum logic {
    SFB_DROP = 1'b0,
    SFB_FWD  = 1'b1
  } sfb_verdict_e;
endpackage

// File: rtl/sfb_elig.sv
// Maps the operating mode and section source onto the set of filters
// that may claim the section.
module sfb_elig #(
  parameter int unsigned NUM_FLT = sfb_pkg::SFB_NUM_FLT
) (
  input  logic               dual_mode,
  input  logic               sec_demod,
  output logic [NUM_FLT-1:0] elig
);
  localparam int unsigned HALF = NUM_FLT / 2;

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_elig
    if (g < HALF) begin : g_low
      assign elig[g] = !dual_mode || !sec_demod;
    end else begin : g_high
      assign elig[g] = !dual_mode || sec_demod;
    end
  end
endmodule

// File: rtl/sfb_pid_stage.sv
// First match stage: enabled, eligible filters whose PID equals the section PID.
module sfb_pid_stage #(
  parameter int unsigned NUM_FLT = sfb_pkg::SFB_NUM_FLT,
  parameter int unsigned PID_W   = sfb_pkg::SFB_PID_W
) (
  input  logic [PID_W-1:0]         sec_pid,
  input  logic [NUM_FLT*PID_W-1:0] flt_pid,
  input  logic [NUM_FLT-1:0]       flt_en,
  input  logic [NUM_FLT-1:0]       elig,
  output logic [NUM_FLT-1:0]       pid_pass
);
  for (genvar g = 0; g < NUM_FLT; g++) begin : g_pid
    logic [PID_W-1:0] ref_pid;
    logic             eq;
    assign ref_pid     = flt_pid[g*PID_W +: PID_W];
    assign eq          = (ref_pid == sec_pid);
    assign pid_pass[g] = flt_en[g] && elig[g] && eq;
  end
endmodule

// File: rtl/sfb_mac_stage.sv
// Second match stage: MAC comparison, qualified by the PID stage.
module sfb_mac_stage #(
  parameter int unsigned NUM_FLT = sfb_pkg::SFB_NUM_FLT,
  parameter int unsigned MAC_W   = sfb_pkg::SFB_MAC_W
) (
  input  logic [MAC_W-1:0]         sec_mac,
  input  logic [NUM_FLT*MAC_W-1:0] flt_mac,
  input  logic [NUM_FLT-1:0]       pid_pass,
  output logic [NUM_FLT-1:0]       hit
);
  for (genvar g = 0; g < NUM_FLT; g++) begin : g_mac
    logic [MAC_W-1:0] ref_mac;
    logic             eq;
    assign ref_mac = flt_mac[g*MAC_W +: MAC_W];
    assign eq      = (ref_mac == sec_mac);
    assign hit[g]  = pid_pass[g] && eq;
  end
endmodule

// File: rtl/sfb_prio.sv
// Lowest-index-wins encoder over the per-filter hit vector.
module sfb_prio #(
  parameter int unsigned NUM_FLT = sfb_pkg::SFB_NUM_FLT,
  localparam int unsigned IDX_W  = $clog2(NUM_FLT)
) (
  input  logic [NUM_FLT-1:0] hit,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_FLT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sfb_filter_bank.sv
module sfb_filter_bank #(
  parameter int unsigned NUM_FLT = sfb_pkg::SFB_NUM_FLT,
  parameter int unsigned PID_W   = sfb_pkg::SFB_PID_W,
  parameter int unsigned MAC_W   = sfb_pkg::SFB_MAC_W,
  localparam int unsigned IDX_W  = $clog2(NUM_FLT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dual_mode,
  input  logic [NUM_FLT-1:0]       flt_en,
  input  logic [NUM_FLT*PID_W-1:0] flt_pid,
  input  logic [NUM_FLT*MAC_W-1:0] flt_mac,
  input  logic                     sec_valid,
  output logic                     sec_ready,
  input  logic                     sec_demod,
  input  logic [PID_W-1:0]         sec_pid,
  input  logic [MAC_W-1:0]         sec_mac,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic                     res_fwd,
  output logic                     res_drop,
  output logic [IDX_W-1:0]         res_idx
);
  import sfb_pkg::*;

  logic [NUM_FLT-1:0] elig;
  logic [NUM_FLT-1:0] pid_pass;
  logic [NUM_FLT-1:0] hit;
  logic               any_hit;
  logic [IDX_W-1:0]   win_idx;

  sfb_elig #(.NUM_FLT(NUM_FLT)) u_elig (
    .dual_mode (dual_mode),
    .sec_demod (sec_demod),
    .elig      (elig)
  );

  sfb_pid_stage #(.NUM_FLT(NUM_FLT), .PID_W(PID_W)) u_pid (
    .sec_pid  (sec_pid),
    .flt_pid  (flt_pid),
    .flt_en   (flt_en),
    .elig     (elig),
    .pid_pass (pid_pass)
  );

  sfb_mac_stage #(.NUM_FLT(NUM_FLT), .MAC_W(MAC_W)) u_mac (
    .sec_mac  (sec_mac),
    .flt_mac  (flt_mac),
    .pid_pass (pid_pass),
    .hit      (hit)
  );

  sfb_prio #(.NUM_FLT(NUM_FLT)) u_prio (
    .hit (hit),
    .any (any_hit),
    .idx (win_idx)
  );

  // Result register with one-deep back-pressure.
  logic             vld_q;
  sfb_verdict_e     verdict_q;
  logic [IDX_W-1:0] idx_q;
  logic             take;

  assign sec_ready = !vld_q || res_ready;
  assign take      = sec_valid && sec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      verdict_q <= SFB_DROP;
      idx_q     <= '0;
    end else if (sec_ready) begin
      vld_q <= sec_valid;
      if (take) begin
        verdict_q <= any_hit ? SFB_FWD : SFB_DROP;
        idx_q     <= any_hit ? win_idx : '0;
      end
    end
  end

  assign res_valid = vld_q;
  assign res_fwd   = vld_q && (verdict_q == SFB_FWD);
  assign res_drop  = vld_q && (verdict_q == SFB_DROP);
  assign res_idx   = idx_q;
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int unsigned NUM_FLT = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_FLT)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dual_mode,
  input logic [NUM_FLT-1:0] flt_en,
  input logic               sec_valid,
  input logic               sec_ready,
  input logic               sec_demod,
  input logic               res_valid,
  input logic               res_ready,
  input logic               res_fwd,
  input logic               res_drop,
  input logic [IDX_W-1:0]   res_idx
);
  localparam int unsigned HALF = NUM_FLT / 2;

  logic [NUM_FLT-1:0] en_at_take;
  always_ff @(posedge clk) begin
    if (!rst_n) en_at_take <= '0;
    else if (sec_valid && sec_ready) en_at_take <= flt_en;
  end

  assert_idle_R10: assert property (@(posedge clk) !rst_n |=> !res_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fwd) && $stable(res_drop) && $stable(res_idx)));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ready) |=> res_valid);

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fwd != res_drop));

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_fwd && !res_drop));

  assert_lowhalf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ready && dual_mode && !sec_demod) |=> !(res_fwd && (int'(res_idx) >= HALF)));

  assert_highhalf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ready && dual_mode && sec_demod) |=> !(res_fwd && (int'(res_idx) < HALF)));

  assert_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_fwd |-> en_at_take[res_idx]);
endmodule

bind sfb_filter_bank sfb_checker #(.NUM_FLT(NUM_FLT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dual_mode (dual_mode),
  .flt_en    (flt_en),
  .sec_valid (sec_valid),
  .sec_ready (sec_ready),
  .sec_demod (sec_demod),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_fwd   (res_fwd),
  .res_drop  (res_drop),
  .res_idx   (res_idx)
);

// File: tb/sim_sfb_filter_bank.sv
`timescale 1ns/1ps
module sim_sfb_filter_bank;
  localparam int NF = 8;
  localparam int PW = 13;
  localparam int MW = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            dual_mode = 1'b0;
  logic [NF-1:0]   flt_en;
  logic [NF*PW-1:0] flt_pid;
  logic [NF*MW-1:0] flt_mac;
  logic            sec_valid = 1'b0;
  logic            sec_ready;
  logic            sec_demod = 1'b0;
  logic [PW-1:0]   sec_pid = '0;
  logic [MW-1:0]   sec_mac = '0;
  logic            res_valid;
  logic            res_ready = 1'b1;
  logic            res_fwd;
  logic            res_drop;
  logic [2:0]      res_idx;

  // Bench-side filter configuration.
  logic          c_en  [NF];
  logic [PW-1:0] c_pid [NF];
  logic [MW-1:0] c_mac [NF];

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      flt_en[i]           = c_en[i];
      flt_pid[i*PW +: PW] = c_pid[i];
      flt_mac[i*MW +: MW] = c_mac[i];
    end
  end

  sfb_filter_bank u0 (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .flt_en(flt_en), .flt_pid(flt_pid), .flt_mac(flt_mac),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_demod(sec_demod),
    .sec_pid(sec_pid), .sec_mac(sec_mac),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_fwd(res_fwd), .res_drop(res_drop), .res_idx(res_idx)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R10";
  bit    done    = 0;

  // Behavioural reference: returns winning filter or -1.
  function automatic int ref_match(bit dual, bit demod, logic [PW-1:0] p, logic [MW-1:0] m);
    for (int i = 0; i < NF; i++) begin
      bit ok_src;
      ok_src = !dual || (demod ? (i >= NF/2) : (i < NF/2));
      if (ok_src && c_en[i] && c_pid[i] == p && c_mac[i] == m) return i;
    end
    return -1;
  endfunction

  bit m_valid = 0, m_fwd = 0, m_acc = 0;
  int m_idx = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 0; m_acc <= 0;
    end else begin
      bit acc;
      int w;
      acc = sec_valid && (!m_valid || res_ready);
      m_acc <= acc;
      if (acc) begin
        w = ref_match(dual_mode, sec_demod, sec_pid, sec_mac);
        m_valid <= 1;
        m_fwd   <= (w >= 0);
        m_idx   <= (w >= 0) ? w : 0;
      end else if (res_ready) begin
        m_valid <= 0;
      end
    end
  end

  task automatic check(bit cond, string req, string what, int act, int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(res_valid == m_valid, cur_req, "res_valid", res_valid, m_valid);
      check(sec_ready == (!m_valid || res_ready), "R9", "sec_ready", sec_ready, !m_valid || res_ready);
      if (m_valid) begin
        check(res_fwd == m_fwd, cur_req, "res_fwd", res_fwd, m_fwd);
        check(res_drop == !m_fwd, cur_req, "res_drop", res_drop, !m_fwd);
        check(int'(res_idx) == m_idx, cur_req, "res_idx", res_idx, m_idx);
      end else begin
        check(!res_fwd && !res_drop, "R5", "strobes idle", {res_fwd, res_drop}, 0);
      end
    end
  end

  task automatic send(bit d, logic [PW-1:0] p, logic [MW-1:0] m);
    @(negedge clk);
    sec_valid = 1; sec_demod = d; sec_pid = p; sec_mac = m;
    do @(negedge clk); while (!m_acc);
    sec_valid = 0;
  endtask

  task automatic pick(int k, int kind, output logic [PW-1:0] p, output logic [MW-1:0] m);
    p = c_pid[k]; m = c_mac[k];
    if (kind == 1) m = m ^ 48'h1;
    else if (kind == 2) p = p ^ 13'h4;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NF; i++) begin
      c_en[i]  = 1;
      c_pid[i] = 13'h100 + 13'(i * 3);
      c_mac[i] = 48'h0200_0000_0010 + 48'(i);
    end
    c_mac[3] = c_mac[7];
    repeat (3) @(negedge clk);
    cur_req = "R10";
    check(res_valid == 0, "R10", "res_valid in reset", res_valid, 0);
    check(sec_ready == 1, "R10", "sec_ready in reset", sec_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check(res_valid == 0 && sec_ready == 1, "R10", "idle after reset", {res_valid, sec_ready}, 1);

    // Single mode basic forward and demod ignored.
    cur_req = "R3";  send(0, c_pid[2], c_mac[2]);
    cur_req = "R6";  send(1, c_pid[2], c_mac[2]);
    cur_req = "R6";  send(1, c_pid[0], c_mac[0]);
    // Near misses.
    cur_req = "R5";  send(0, 13'h1FFF, 48'h0);
    cur_req = "R2";  send(0, c_pid[4], c_mac[4] ^ 48'h80);
    cur_req = "R2";  send(0, c_pid[6], c_mac[3]); // MAC of 3/7, PID of 6
    // Disabled filter.
    @(negedge clk); c_en[2] = 0;
    cur_req = "R1";  send(0, c_pid[2], c_mac[2]);
    @(negedge clk); c_en[2] = 1;
    // Duplicates: filter 5 becomes copy of filter 1.
    @(negedge clk); c_pid[5] = c_pid[1]; c_mac[5] = c_mac[1];
    cur_req = "R4";  send(1, c_pid[1], c_mac[1]);
    // Dual mode partitioning.
    @(negedge clk); dual_mode = 1;
    cur_req = "R7";  send(1, c_pid[1], c_mac[1]);
    cur_req = "R7";  send(0, c_pid[1], c_mac[1]);
    cur_req = "R7";  send(1, c_pid[2], c_mac[2]);
    cur_req = "R7";  send(0, c_pid[6], c_mac[6]);
    @(negedge clk); c_en[5] = 0;
    cur_req = "R1";  send(1, c_pid[1], c_mac[1]);
    @(negedge clk); c_en[5] = 1; dual_mode = 0;

    // Back-pressure: result held, input stalled.
    cur_req = "R9";
    @(negedge clk); res_ready = 0;
    send(0, c_pid[3], c_mac[3]);
    sec_valid = 1; sec_demod = 0; sec_pid = c_pid[7]; sec_mac = c_mac[7];
    repeat (5) @(negedge clk);
    res_ready = 1;
    do @(negedge clk); while (!m_acc);
    sec_valid = 0;
    repeat (2) @(negedge clk);

    // Randomised traffic, latency R8 checked every cycle by comparison.
    cur_req = "R8";
    for (int cyc = 0; cyc < 1500; cyc++) begin
      @(negedge clk);
      res_ready = ($urandom % 4) != 0;
      if (cyc % 100 == 0 && !sec_valid) dual_mode = $urandom % 2;
      if (!sec_valid || m_acc) begin
        logic [PW-1:0] p;
        logic [MW-1:0] m;
        pick($urandom % NF, $urandom % 4, p, m);
        sec_valid = ($urandom % 3) != 0;
        sec_demod = $urandom % 2;
        sec_pid = p; sec_mac = m;
      end
    end
    @(negedge clk); sec_valid = 0; res_ready = 1;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule